// File: doc/BRIEF.md
# Debug Access Guard with Breakpoint Comparators

This block decides whether the two-wire serial debug port of a small 32-bit CPU may be used. It also watches the CPU's instruction fetches and data accesses for configured addresses. Debug starts out enabled. Firmware can switch it off with one register write. After that, no firmware write can switch it back on. Only the erase-complete pulse from the flash controller clears the lock. That pulse arrives after a full device erase, which is followed by clearing protection and loading a new image. An ordinary reset does not clear the lock. It reloads the lock from a non-volatile copy supplied on an input.

Four instruction-address breakpoints and two data-address watchpoints each have their own enable. Each watchpoint can match on reads, on writes or on both. A hit from any enabled comparator produces a one-cycle halt request to the core and records which comparator fired. Hits are dropped while debug is locked. A pin select hands the two debug pins to general-purpose I/O in two cases: when debug is locked, or when firmware asks for the pins.

Firmware configures the block through a simple write strobe with a register select and 32 bits of data:

| Select | Register |
|---|---|
| 0 | control |
| 1 | enables |
| 2 to 5 | breakpoint addresses 0 to 3 |
| 6 to 7 | watchpoint addresses 0 to 1 |

Top module: `dbg_guard_top`

## Requirements
- R1: During reset (synchronous, active high), the lock is loaded from `nv_lock_i`. After reset, `dbg_en_o` equals the inverse of that value. Reset also clears `halt_o`, `hit_idx_o`, the GPIO request and all comparator enables.
- R2: A write to select 0 with data bit 0 set locks debug from the next cycle on, so `dbg_en_o` goes to 0. Once locked, no firmware write clears the lock, whatever its data.
- R3: A one-cycle `erase_done_i` pulse clears the lock from the next cycle on. If a locking write arrives in the same cycle, the erase wins.
- R4: Breakpoint k (0 to 3) has its address at select 2+k and its enable at bit k of select 1. When that comparator is enabled and a valid fetch address equals its address, `halt_o` is 1 in the following cycle and `hit_idx_o` is k.
- R5: Watchpoint j (0 to 1) has its address at select 6+j. Its read-match enable is bit 4+2j of select 1 and its write-match enable is bit 5+2j. A valid data access to that address (`data_wr_i` is 1 for a write) hits only when the enable for its direction is set. A hit reports `hit_idx_o` = 4+j in the following cycle.
- R6: A disabled comparator, or a valid access whose address matches no enabled comparator, never raises `halt_o`.
- R7: When several comparators hit in the same cycle, `hit_idx_o` reports the lowest index. Breakpoints rank below watchpoints.
- R8: `halt_o` is high for exactly the cycles that follow a hitting cycle. `hit_idx_o` keeps its value until the next hit.
- R9: While debug is locked, hits raise no halt and leave `hit_idx_o` unchanged.
- R10: `pin_gpio_o` is 1 whenever debug is locked or the GPIO request (select 0, data bit 1) is set. Otherwise it is 0, so the debug pins keep their debug function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_lock_i | input | 1 | Non-volatile copy of the lock, loaded at reset |
| erase_done_i | input | 1 | Full-erase-complete pulse from the flash controller |
| cfg_we_i | input | 1 | Firmware register write strobe |
| cfg_sel_i | input | 4 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| fetch_valid_i | input | 1 | Instruction fetch in progress |
| fetch_addr_i | input | 32 | Instruction fetch address |
| data_valid_i | input | 1 | Data access in progress |
| data_addr_i | input | 32 | Data access address |
| data_wr_i | input | 1 | Data access is a write (1) or a read (0) |
| dbg_en_o | output | 1 | Debug port enabled |
| halt_o | output | 1 | One-cycle halt request on a comparator hit |
| hit_idx_o | output | 3 | Index of the comparator that last hit |
| pin_gpio_o | output | 1 | Debug pins assigned to general-purpose I/O |

## Verification
Errors in the lock state appear at the ports at once. A lock that was wrongly cleared or wrongly kept shows on `dbg_en_o` and `pin_gpio_o` in the first cycle after the write, erase or reset that should have set it. It also shows as a halt that appears or goes missing on the next matching fetch. A wrong enable or mode bit, or a wrong address register, changes `halt_o` exactly one cycle after a matching access. The sweeps cover every enable mask and every watchpoint mode against both access directions. A wrong priority or a stale index shows on `hit_idx_o` in that same cycle and stays there until the next hit.

// File: rtl/dbg_guard_pkg.sv
package dbg_guard_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = 4;
    localparam int NUM_BP   = 4;
    localparam int NUM_WP   = 2;
    localparam int NUM_CMP  = NUM_BP + NUM_WP;
    localparam int IDX_W    = $clog2(NUM_CMP);
    localparam int ENA_USED = NUM_BP + 2 * NUM_WP;

    localparam logic [SEL_W-1:0] SEL_CTRL    = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_ENA     = SEL_W'(1);
    localparam int               SEL_BP_BASE = 2;
    localparam int               SEL_WP_BASE = SEL_BP_BASE + NUM_BP;

    localparam int CTRL_LOCK_BIT = 0;
    localparam int CTRL_GPIO_BIT = 1;

    typedef struct packed {
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } cfg_wr_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } fetch_t;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } dacc_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } wp_mode_t;

    // Lowest set bit wins; returns 0 for an empty vector.
    function automatic logic [IDX_W-1:0] lowest_hit(input logic [NUM_CMP-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl
    import dbg_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    nv_lock_i,
    input  logic    erase_done_i,
    input  cfg_wr_t cfg_i,
    output logic    lock_o,
    output logic    gpio_req_o
);

    logic lock_q;
    logic gpio_q;
    logic ctrl_wr;

    assign ctrl_wr = cfg_i.we && (cfg_i.sel == SEL_CTRL);

    // Sticky lock: firmware can only set it, erase only clears it.
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= nv_lock_i;
        end else if (erase_done_i) begin
            lock_q <= 1'b0;
        end else if (ctrl_wr && cfg_i.data[CTRL_LOCK_BIT]) begin
            lock_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gpio_q <= 1'b0;
        end else if (ctrl_wr) begin
            gpio_q <= cfg_i.data[CTRL_GPIO_BIT];
        end
    end

    assign lock_o     = lock_q;
    assign gpio_req_o = gpio_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !erase_done_i) |=> lock_q);  // R2

    AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        erase_done_i |=> !lock_q);  // R3

endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
    import dbg_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_wr_t          cfg_i,
    input  fetch_t           fetch_i,
    input  dacc_t            dacc_i,
    input  logic             dbg_en_i,
    output logic             halt_o,
    output logic [IDX_W-1:0] hit_idx_o
);

    logic [ADDR_W-1:0]  bp_addr_q [NUM_BP];
    logic [ADDR_W-1:0]  wp_addr_q [NUM_WP];
    logic [NUM_BP-1:0]  bp_en_q;
    wp_mode_t           wp_mode_q [NUM_WP];
    logic [NUM_CMP-1:0] hit_vec;
    logic               any_hit;
    logic               take_hit;
    logic               halt_q;
    logic [IDX_W-1:0]   idx_q;
    logic               ena_wr;
    logic               unused_ena_bits;

    assign ena_wr          = cfg_i.we && (cfg_i.sel == SEL_ENA);
    assign unused_ena_bits = ^cfg_i.data[DATA_W-1:ENA_USED];

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_en_q <= '0;
        end else if (ena_wr) begin
            bp_en_q <= cfg_i.data[NUM_BP-1:0];
        end
    end

    for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(SEL_BP_BASE + k);

        always_ff @(posedge clk) begin
            if (rst) begin
                bp_addr_q[k] <= '0;
            end else if (cfg_i.we && cfg_i.sel == MY_SEL) begin
                bp_addr_q[k] <= cfg_i.data[ADDR_W-1:0];
            end
        end

        assign hit_vec[k] = bp_en_q[k] && fetch_i.valid
                            && (fetch_i.addr == bp_addr_q[k]);
    end

    for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(SEL_WP_BASE + j);
        localparam int               RD_BIT = NUM_BP + 2 * j;
        localparam int               WR_BIT = NUM_BP + 2 * j + 1;
        logic dir_ok;

        always_ff @(posedge clk) begin
            if (rst) begin
                wp_addr_q[j] <= '0;
            end else if (cfg_i.we && cfg_i.sel == MY_SEL) begin
                wp_addr_q[j] <= cfg_i.data[ADDR_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                wp_mode_q[j] <= '0;
            end else if (ena_wr) begin
                wp_mode_q[j].rd <= cfg_i.data[RD_BIT];
                wp_mode_q[j].wr <= cfg_i.data[WR_BIT];
            end
        end

        assign dir_ok = dacc_i.wr ? wp_mode_q[j].wr : wp_mode_q[j].rd;
        assign hit_vec[NUM_BP + j] = dir_ok && dacc_i.valid
                                     && (dacc_i.addr == wp_addr_q[j]);
    end

    assign any_hit  = |hit_vec;
    assign take_hit = any_hit && dbg_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            halt_q <= take_hit;
            if (take_hit) begin
                idx_q <= lowest_hit(hit_vec);
            end
        end
    end

    assign halt_o    = halt_q;
    assign hit_idx_o = idx_q;

    AST_NO_HALT_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !dbg_en_i |=> !halt_q);  // R9

    AST_IDX_HELD: assert property (@(posedge clk) disable iff (rst)
        !halt_q |-> $stable(idx_q));  // R8

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        halt_q |-> (idx_q < IDX_W'(NUM_CMP)));  // R7

    AST_HALT_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
        !any_hit |=> !halt_q);  // R6

endmodule

// File: rtl/dbg_pin_mux.sv
module dbg_pin_mux (
    input  logic lock_i,
    input  logic gpio_req_i,
    output logic pin_gpio_o
);

    always_comb begin
        pin_gpio_o = lock_i | gpio_req_i;
    end

endmodule

// File: rtl/dbg_guard_top.sv
module dbg_guard_top
    import dbg_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nv_lock_i,
    input  logic              erase_done_i,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              data_valid_i,
    input  logic [ADDR_W-1:0] data_addr_i,
    input  logic              data_wr_i,
    output logic              dbg_en_o,
    output logic              halt_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output logic              pin_gpio_o
);

    cfg_wr_t cfg;
    fetch_t  fetch;
    dacc_t   dacc;
    logic    lock;
    logic    gpio_req;

    assign cfg   = '{we: cfg_we_i, sel: cfg_sel_i, data: cfg_wdata_i};
    assign fetch = '{valid: fetch_valid_i, addr: fetch_addr_i};
    assign dacc  = '{valid: data_valid_i, wr: data_wr_i, addr: data_addr_i};

    dbg_lock_ctrl u_lock (
        .clk          (clk),
        .rst          (rst),
        .nv_lock_i    (nv_lock_i),
        .erase_done_i (erase_done_i),
        .cfg_i        (cfg),
        .lock_o       (lock),
        .gpio_req_o   (gpio_req)
    );

    assign dbg_en_o = ~lock;

    dbg_cmp_bank u_cmp (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg),
        .fetch_i   (fetch),
        .dacc_i    (dacc),
        .dbg_en_i  (dbg_en_o),
        .halt_o    (halt_o),
        .hit_idx_o (hit_idx_o)
    );

    dbg_pin_mux u_pins (
        .lock_i     (lock),
        .gpio_req_i (gpio_req),
        .pin_gpio_o (pin_gpio_o)
    );

    AST_PINS_GPIO_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !dbg_en_o |-> pin_gpio_o);  // R10

endmodule

// File: tb/dbg_guard_top_tb_top.sv
`timescale 1ns/1ps
module dbg_guard_top_tb_top;

    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        nv_lock_i;
    logic        erase_done_i;
    logic        cfg_we_i;
    logic [3:0]  cfg_sel_i;
    logic [31:0] cfg_wdata_i;
    logic        fetch_valid_i;
    logic [31:0] fetch_addr_i;
    logic        data_valid_i;
    logic [31:0] data_addr_i;
    logic        data_wr_i;
    logic        dbg_en_o;
    logic        halt_o;
    logic [2:0]  hit_idx_o;
    logic        pin_gpio_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int last_idx = 0;

    always #(CLK_NS / 2) clk = ~clk;

    dbg_guard_top dut_i (
        .clk(clk), .rst(rst), .nv_lock_i(nv_lock_i), .erase_done_i(erase_done_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
        .data_valid_i(data_valid_i), .data_addr_i(data_addr_i), .data_wr_i(data_wr_i),
        .dbg_en_o(dbg_en_o), .halt_o(halt_o), .hit_idx_o(hit_idx_o), .pin_gpio_o(pin_gpio_o)
    );

    function automatic logic [31:0] bp_addr(input int k);
        return 32'h1000_0000 + 32'(k) * 32'h10;
    endfunction

    function automatic logic [31:0] wp_addr(input int j);
        return 32'h2000_0100 + 32'(j) * 32'h8;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        tick();
        cfg_we_i = 1'b0;
    endtask

    task automatic do_reset(input logic nv);
        nv_lock_i = nv;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        last_idx = 0;
    endtask

    task automatic fetch(input logic [31:0] a);
        fetch_valid_i = 1'b1; fetch_addr_i = a;
        tick();
        fetch_valid_i = 1'b0;
    endtask

    task automatic dacc(input logic [31:0] a, input logic w);
        data_valid_i = 1'b1; data_addr_i = a; data_wr_i = w;
        tick();
        data_valid_i = 1'b0;
    endtask

    task automatic prog_addrs();
        for (int k = 0; k < 4; k++) wr(4'(2 + k), bp_addr(k));
        for (int j = 0; j < 2; j++) wr(4'(6 + j), wp_addr(j));
    endtask

    initial begin
        rst = 1'b1; nv_lock_i = 1'b0; erase_done_i = 1'b0;
        cfg_we_i = 1'b0; cfg_sel_i = '0; cfg_wdata_i = '0;
        fetch_valid_i = 1'b0; fetch_addr_i = '0;
        data_valid_i = 1'b0; data_addr_i = '0; data_wr_i = 1'b0;

        // R1: reset state with unlocked non-volatile copy
        do_reset(1'b0);
        chk("R1 dbg_en", 32'(dbg_en_o), 1);
        chk("R1 halt", 32'(halt_o), 0);
        chk("R1 idx", 32'(hit_idx_o), 0);
        chk("R1 pins", 32'(pin_gpio_o), 0);
        fetch(32'h0);
        chk("R1 enables cleared", 32'(halt_o), 0);

        prog_addrs();

        // R4 R6 R8: sweep every breakpoint enable mask against every breakpoint address
        for (int m = 0; m < 16; m++) begin
            wr(4'd1, 32'(m));
            for (int k = 0; k < 4; k++) begin
                fetch(bp_addr(k));
                if (m[k]) last_idx = k;
                chk("R4/R6 bp halt", 32'(halt_o), 32'(m[k]));
                chk("R8 idx", 32'(hit_idx_o), 32'(last_idx));
                tick();
                chk("R8 one-cycle halt", 32'(halt_o), 0);
                chk("R8 idx held", 32'(hit_idx_o), 32'(last_idx));
            end
        end

        // R5: every watchpoint mode against both directions
        for (int j = 0; j < 2; j++) begin
            for (int md = 0; md < 4; md++) begin
                wr(4'd1, 32'(md) << (4 + 2 * j));
                for (int w = 0; w < 2; w++) begin
                    dacc(wp_addr(j), w[0]);
                    if (md[w]) last_idx = 4 + j;
                    chk("R5 wp halt", 32'(halt_o), 32'(md[w]));
                    chk("R5 wp idx", 32'(hit_idx_o), 32'(last_idx));
                end
            end
        end

        // R6: everything enabled, non-matching addresses
        wr(4'd1, 32'hFF);
        fetch(32'hDEAD_0000);
        chk("R6 fetch miss", 32'(halt_o), 0);
        dacc(bp_addr(0), 1'b1);
        chk("R6 data miss", 32'(halt_o), 0);
        chk("R6 idx unchanged", 32'(hit_idx_o), 32'(last_idx));

        // R7: two breakpoints on one address, lowest index reported
        wr(4'd5, bp_addr(2));
        wr(4'd1, 32'hC);
        fetch(bp_addr(2));
        chk("R7 bp priority halt", 32'(halt_o), 1);
        chk("R7 bp priority idx", 32'(hit_idx_o), 2);
        wr(4'd5, bp_addr(3));

        // R7: breakpoint and watchpoint together
        wr(4'd1, 32'h18);
        fetch_valid_i = 1'b1; fetch_addr_i = bp_addr(3);
        data_valid_i = 1'b1; data_addr_i = wp_addr(0); data_wr_i = 1'b0;
        tick();
        fetch_valid_i = 1'b0; data_valid_i = 1'b0;
        chk("R7 bp over wp", 32'(hit_idx_o), 3);
        dacc(wp_addr(0), 1'b0);
        chk("R7 wp alone idx", 32'(hit_idx_o), 4);
        last_idx = 4;

        // R10: GPIO request while unlocked
        wr(4'd0, 32'h2);
        chk("R10 gpio req", 32'(pin_gpio_o), 1);
        chk("R10 still enabled", 32'(dbg_en_o), 1);
        wr(4'd0, 32'h0);
        chk("R10 gpio release", 32'(pin_gpio_o), 0);

        // R2: lock and attempt to unlock
        wr(4'd0, 32'h1);
        chk("R2 locked", 32'(dbg_en_o), 0);
        chk("R10 pins when locked", 32'(pin_gpio_o), 1);
        wr(4'd0, 32'h0);
        chk("R2 stays locked", 32'(dbg_en_o), 0);
        wr(4'd0, 32'hFFFF_FFFE);
        chk("R2 stays locked any data", 32'(dbg_en_o), 0);

        // R9: hits ignored while locked
        wr(4'd1, 32'h1);
        fetch(bp_addr(0));
        chk("R9 no halt", 32'(halt_o), 0);
        chk("R9 idx unchanged", 32'(hit_idx_o), 32'(last_idx));

        // R3: erase unlocks
        erase_done_i = 1'b1; tick(); erase_done_i = 1'b0;
        chk("R3 erase unlocks", 32'(dbg_en_o), 1);
        fetch(bp_addr(0));
        chk("R3 halts again", 32'(halt_o), 1);

        // R1: reset reloads the non-volatile lock
        do_reset(1'b1);
        chk("R1 nv lock", 32'(dbg_en_o), 0);
        chk("R1 nv pins", 32'(pin_gpio_o), 1);
        chk("R1 idx reset", 32'(hit_idx_o), 0);

        // R3: erase beats a same-cycle locking write
        erase_done_i = 1'b1;
        wr(4'd0, 32'h1);
        erase_done_i = 1'b0;
        chk("R3 erase wins", 32'(dbg_en_o), 1);
        chk("R10 pins back", 32'(pin_gpio_o), 0);

        do_reset(1'b0);
        chk("R1 nv clear", 32'(dbg_en_o), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule